// File: doc/BRIEF.md
# Pad Output-Enable Control Cell

This cell sits between one logic cell of a programmable logic device and its pin. It takes the logic cell's data bit and product-term output enable. It also takes a small set of global three-state lines, a programming-mode flag and static configuration bits. From these it produces the value driven onto the pad, the pad's tristate enable, a pull-up request, and the value that the device logic sees coming back from the pin. Slew shaping, drive strength and real resistors are not modelled. The pad is a data/enable pair, a pull-up flag and an external input bit.

A 3-bit select picks the output-enable source. The source can be the local product term, one of the global three-state lines (each through its own configurable inversion), or a constant. Two overrides sit above that selection. A ground-tie option turns the pin into a driven-low ground terminal. The programming-mode flag disconnects the logic and pulls the pin high. The drive, enable and pull-up outputs are registered once on `clk_i`. The returned input value is resolved combinationally from those registers and the external pad bit.

Top module: `iocell_pad_ctrl`

## Requirements
- R1: While `rst_ni` is low and after its release until the first clock edge, `pad_o`, `pad_oe_o` and `pad_pu_o` are 0, and `in_o` equals `pad_i`.
- R2: With select code 0 and no override, after the next rising edge `pad_oe_o` equals the earlier `pt_oe_i` and `pad_o` equals the earlier `data_i`. Before that edge, the outputs keep their previous values.
- R3: Select codes 1, 2, 3 and 4 pick global line 0, 1, 2 and 3 (after inversion) as the enable. A code whose line index is not below NUM_GTS gives enable 0. The reserved code 5 also gives enable 0.
- R4: Bit i of `cfg_gts_inv_i` set inverts global line i before selection.
- R5: Select code 6 holds the enable at 1 and code 7 holds it at 0, whatever the product term and global lines are.
- R6: With `cfg_gnd_i` set, the registered outputs become `pad_oe_o`=1, `pad_o`=0 and `pad_pu_o`=0, whatever the data and select are.
- R7: With `prog_i` set and `cfg_gnd_i` clear, the registered outputs become `pad_pu_o`=1, `pad_oe_o`=0 and `pad_o`=1, and `in_o` reads 1.
- R8: With `prog_i` clear, `pad_pu_o` is 0 after the next edge and the pull-up has no effect on `in_o`.
- R9: When `pad_pu_o` is 0, `in_o` equals `pad_o` if `pad_oe_o` is 1 and `pad_i` otherwise. It follows `pad_i` without waiting for a clock edge.
- R10: When `cfg_gnd_i` and `prog_i` are both set, the ground tie wins: the outputs follow R6 and `in_o` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the pad drive registers |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 1 | Data bit from the logic cell |
| pt_oe_i | input | 1 | Product-term output enable from the logic cell |
| gts_i | input | NUM_GTS | Global three-state control lines |
| prog_i | input | 1 | Programming-mode flag |
| cfg_oe_sel_i | input | 3 | Output-enable source select (0 product term, 1-4 global line, 5 reserved, 6 on, 7 off) |
| cfg_gts_inv_i | input | NUM_GTS | Per-line inversion of the global three-state lines |
| cfg_gnd_i | input | 1 | Ground-tie option |
| pad_i | input | 1 | Value present on the external pin |
| pad_o | output | 1 | Value driven onto the pin |
| pad_oe_o | output | 1 | Tristate enable of the pin driver |
| pad_pu_o | output | 1 | Pull-up request on the pin |
| in_o | output | 1 | Resolved input value returned to the logic |

## Verification
The clocked assertions assume that configuration and control inputs are stable for the full cycle before the edge they are judged at. They compare each registered output with the inputs one edge earlier, starting only after the first edge out of reset. The stimulus changes every input on the falling edge and samples on the next falling edge, so each vector spans exactly one rising edge. `pad_i` is the only input read combinationally. It is toggled between edges to show that `in_o` tracks it without a clock.

// File: rtl/iocell_pkg.sv
package iocell_pkg;
  localparam int unsigned OE_SEL_W = 3;

  typedef enum logic [OE_SEL_W-1:0] {
    OE_SRC_PTERM = 3'd0,
    OE_SRC_G0    = 3'd1,
    OE_SRC_G1    = 3'd2,
    OE_SRC_G2    = 3'd3,
    OE_SRC_G3    = 3'd4,
    OE_SRC_RSVD  = 3'd5,
    OE_SRC_ON    = 3'd6,
    OE_SRC_OFF   = 3'd7
  } oe_src_e;

  typedef struct packed {
    logic out;
    logic oe;
    logic pu;
  } pad_drv_t;
endpackage

// File: rtl/iocell_gts_pol.sv
module iocell_gts_pol #(
  parameter int unsigned NUM_GTS = 4
) (
  input  logic [NUM_GTS-1:0] gts_i,
  input  logic [NUM_GTS-1:0] inv_i,
  output logic [NUM_GTS-1:0] gts_o
);
  for (genvar g = 0; g < NUM_GTS; g++) begin : g_pol
    assign gts_o[g] = gts_i[g] ^ inv_i[g];
  end
endmodule

// File: rtl/iocell_oe_mux.sv
module iocell_oe_mux
  import iocell_pkg::*;
#(
  parameter int unsigned NUM_GTS = 4
) (
  input  logic [OE_SEL_W-1:0] sel_i,
  input  logic                pt_oe_i,
  input  logic [NUM_GTS-1:0]  gts_i,
  output logic                oe_o
);
  localparam int unsigned GTS_FIRST = 1;

  logic gts_pick;

  always_comb begin
    gts_pick = 1'b0;
    for (int unsigned k = 0; k < NUM_GTS; k++) begin
      if (int'(sel_i) == int'(k + GTS_FIRST)) gts_pick = gts_i[k];
    end
  end

  always_comb begin
    unique case (oe_src_e'(sel_i))
      OE_SRC_PTERM: oe_o = pt_oe_i;
      OE_SRC_G0,
      OE_SRC_G1,
      OE_SRC_G2,
      OE_SRC_G3:    oe_o = gts_pick;
      OE_SRC_ON:    oe_o = 1'b1;
      default:      oe_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/iocell_drive.sv
module iocell_drive
  import iocell_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic data_i,
  input  logic oe_i,
  input  logic gnd_i,
  input  logic prog_i,
  output logic pad_o,
  output logic pad_oe_o,
  output logic pad_pu_o
);
  pad_drv_t nxt, cur;

  // priority: ground tie, then programming pull-up, then normal path
  always_comb begin
    if (gnd_i)       nxt = '{out: 1'b0,   oe: 1'b1, pu: 1'b0};
    else if (prog_i) nxt = '{out: 1'b1,   oe: 1'b0, pu: 1'b1};
    else             nxt = '{out: data_i, oe: oe_i, pu: 1'b0};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cur <= '0;
    else         cur <= nxt;
  end

  assign pad_o    = cur.out;
  assign pad_oe_o = cur.oe;
  assign pad_pu_o = cur.pu;

  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  p_gnd_tie_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && gnd_i |=> pad_oe_o && !pad_o && !pad_pu_o);
  p_gnd_over_prog_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && gnd_i && prog_i |=> !pad_pu_o && pad_oe_o);
  p_prog_pullup_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && prog_i && !gnd_i |=> pad_pu_o && !pad_oe_o && pad_o);
  p_pu_detached_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && !prog_i |=> !pad_pu_o);
  p_pu_excl_oe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pad_pu_o && pad_oe_o));
endmodule

// File: rtl/iocell_pad_ctrl.sv
module iocell_pad_ctrl
  import iocell_pkg::*;
#(
  parameter int unsigned NUM_GTS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                data_i,
  input  logic                pt_oe_i,
  input  logic [NUM_GTS-1:0]  gts_i,
  input  logic                prog_i,
  input  logic [OE_SEL_W-1:0] cfg_oe_sel_i,
  input  logic [NUM_GTS-1:0]  cfg_gts_inv_i,
  input  logic                cfg_gnd_i,
  input  logic                pad_i,
  output logic                pad_o,
  output logic                pad_oe_o,
  output logic                pad_pu_o,
  output logic                in_o
);
  logic [NUM_GTS-1:0] gts_pol;
  logic               oe_sel;

  iocell_gts_pol #(.NUM_GTS(NUM_GTS)) u_pol (
    .gts_i (gts_i),
    .inv_i (cfg_gts_inv_i),
    .gts_o (gts_pol)
  );

  iocell_oe_mux #(.NUM_GTS(NUM_GTS)) u_mux (
    .sel_i   (cfg_oe_sel_i),
    .pt_oe_i (pt_oe_i),
    .gts_i   (gts_pol),
    .oe_o    (oe_sel)
  );

  iocell_drive u_drv (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .data_i   (data_i),
    .oe_i     (oe_sel),
    .gnd_i    (cfg_gnd_i),
    .prog_i   (prog_i),
    .pad_o    (pad_o),
    .pad_oe_o (pad_oe_o),
    .pad_pu_o (pad_pu_o)
  );

  // pin value seen by logic: pull-up, else own drive, else external
  assign in_o = pad_pu_o ? 1'b1 : (pad_oe_o ? pad_o : pad_i);

  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  logic normal;
  assign normal = !cfg_gnd_i && !prog_i;

  p_pterm_path_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && normal && cfg_oe_sel_i == OE_SRC_PTERM
    |=> pad_oe_o == $past(pt_oe_i) && pad_o == $past(data_i));
  p_const_on_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && normal && cfg_oe_sel_i == OE_SRC_ON |=> pad_oe_o);
  p_const_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && normal && cfg_oe_sel_i == OE_SRC_OFF |=> !pad_oe_o);
  p_rsvd_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && normal && cfg_oe_sel_i == OE_SRC_RSVD |=> !pad_oe_o);
  p_gts0_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && normal && cfg_oe_sel_i == OE_SRC_G0
    |=> pad_oe_o == $past(gts_i[0] ^ cfg_gts_inv_i[0]));
  p_in_resolve_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pad_pu_o |-> in_o == (pad_oe_o ? pad_o : pad_i));
  p_in_prog_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pad_pu_o |-> in_o);
endmodule

// File: tb/iocell_pad_ctrl_bench.sv
module iocell_pad_ctrl_bench;
  localparam int unsigned NUM_GTS = 4;
  localparam time CLK_PERIOD = 10ns;
  localparam int NVEC = 15;

  typedef struct packed {
    logic [2:0] sel;
    logic       gnd;
    logic       prog;
    logic [3:0] inv;
    logic [3:0] gts;
    logic       pt;
    logic       data;
    logic       padi;
    logic       e_oe;
    logic       e_out;
    logic       e_pu;
    logic       e_in;
    logic [3:0] req;
  } vec_t;

  // sel gnd prog inv gts pt data padi | oe out pu in | req
  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 1'b0, 1'b0, 4'b0000, 4'b0000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'd2},
    '{3'd0, 1'b0, 1'b0, 4'b0000, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd9},
    '{3'd0, 1'b0, 1'b0, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd9},
    '{3'd1, 1'b0, 1'b0, 4'b0000, 4'b0001, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd3},
    '{3'd2, 1'b0, 1'b0, 4'b0000, 4'b0001, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd3},
    '{3'd4, 1'b0, 1'b0, 4'b0000, 4'b1000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'd3},
    '{3'd3, 1'b0, 1'b0, 4'b0100, 4'b0100, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd4},
    '{3'd2, 1'b0, 1'b0, 4'b0010, 4'b0000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd4},
    '{3'd6, 1'b0, 1'b0, 4'b0000, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'd5},
    '{3'd7, 1'b0, 1'b0, 4'b0000, 4'b1111, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd5},
    '{3'd5, 1'b0, 1'b0, 4'b0000, 4'b1111, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd3},
    '{3'd7, 1'b1, 1'b0, 4'b0000, 4'b0000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd6},
    '{3'd6, 1'b0, 1'b1, 4'b0000, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd7},
    '{3'd6, 1'b1, 1'b1, 4'b0000, 4'b0000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd10},
    '{3'd7, 1'b0, 1'b0, 4'b0000, 4'b0000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'd8}
  };

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic               data_i = 1'b0;
  logic               pt_oe_i = 1'b0;
  logic [NUM_GTS-1:0] gts_i = '0;
  logic               prog_i = 1'b0;
  logic [2:0]         cfg_oe_sel_i = 3'd0;
  logic [NUM_GTS-1:0] cfg_gts_inv_i = '0;
  logic               cfg_gnd_i = 1'b0;
  logic               pad_i = 1'b0;
  logic               pad_o, pad_oe_o, pad_pu_o, in_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  iocell_pad_ctrl #(.NUM_GTS(NUM_GTS)) u_iocell_pad_ctrl (
    .clk_i, .rst_ni, .data_i, .pt_oe_i, .gts_i, .prog_i,
    .cfg_oe_sel_i, .cfg_gts_inv_i, .cfg_gnd_i, .pad_i,
    .pad_o, .pad_oe_o, .pad_pu_o, .in_o
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk_i);
    cfg_oe_sel_i  = v.sel;
    cfg_gnd_i     = v.gnd;
    prog_i        = v.prog;
    cfg_gts_inv_i = v.inv;
    gts_i         = v.gts;
    pt_oe_i       = v.pt;
    data_i        = v.data;
    pad_i         = v.padi;
    @(negedge clk_i);
  endtask

  initial begin
    // R1: reset state
    pad_i = 1'b1;
    #(CLK_PERIOD * 2);
    check("R1", "pad_oe_o", pad_oe_o, 1'b0);
    check("R1", "pad_o", pad_o, 1'b0);
    check("R1", "pad_pu_o", pad_pu_o, 1'b0);
    check("R1", "in_o", in_o, 1'b1);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      string r;
      apply(VECS[i]);
      r = $sformatf("R%0d", VECS[i].req);
      check(r, "pad_oe_o", pad_oe_o, VECS[i].e_oe);
      check(r, "pad_o", pad_o, VECS[i].e_out);
      check(r, "pad_pu_o", pad_pu_o, VECS[i].e_pu);
      check(r, "in_o", in_o, VECS[i].e_in);
    end

    // R9: in_o tracks pad_i between edges while undriven (last vector: sel 7)
    #1 pad_i = 1'b0;
    #1 check("R9", "in_o follows pad_i low", in_o, 1'b0);
    pad_i = 1'b1;
    #1 check("R9", "in_o follows pad_i high", in_o, 1'b1);

    // R2: enable change is not visible before the rising edge
    @(negedge clk_i);
    cfg_oe_sel_i = 3'd0;
    pt_oe_i = 1'b1;
    data_i = 1'b0;
    #1 check("R2", "oe held before edge", pad_oe_o, 1'b0);
    @(negedge clk_i);
    check("R2", "oe after edge", pad_oe_o, 1'b1);
    check("R2", "data after edge", pad_o, 1'b0);

    // R8: leaving programming mode detaches pull-up on next edge
    @(negedge clk_i);
    prog_i = 1'b1;
    @(negedge clk_i);
    check("R7", "pull-up in prog", pad_pu_o, 1'b1);
    prog_i = 1'b0;
    pt_oe_i = 1'b0;
    pad_i = 1'b0;
    @(negedge clk_i);
    check("R8", "pull-up released", pad_pu_o, 1'b0);
    check("R8", "in_o no pull-up", in_o, 1'b0);

    // R1: asynchronous reset mid-run
    @(negedge clk_i);
    cfg_gnd_i = 1'b1;
    @(negedge clk_i);
    #1 rst_ni = 1'b0;
    pad_i = 1'b1;
    #1 check("R1", "oe cleared by reset", pad_oe_o, 1'b0);
    check("R1", "in_o after reset", in_o, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule